// File: doc/BRIEF.md
# Windowed Integer Register File

This block stores the integer registers of a processor whose register set is split into shared globals and a ring of overlapping windows. Software sees 32 logical registers at any moment. Eight of them are globals common to every window. The other 24 are taken from the window that the current window pointer selects. Two combinational read ports and one clocked write port take 5-bit logical numbers. The block maps each number onto a physical entry through the pointer.

A 2-bit command input moves the pointer. A save steps the pointer down by one and wraps from 0 to the highest window. A restore or a return-from-trap steps it up by one, with the same wrap. Each window shares 8 physical registers with each neighbour. The outgoing group of a caller therefore becomes the incoming group of the window that a save enters. An invalid-window bitmask guards every move. If a move would land on a marked window, the pointer stays where it is and an overflow or underflow flag is raised instead. Software can load the mask. The block does not decode instructions, does not service traps and does not move data to or from memory.

Top module: `winreg_file`

## Requirements
- R1: Logical registers 1 to 7 are globals: one physical copy each, seen unchanged from every window.
- R2: Logical register 0 reads as zero on both read ports, and any write to it is dropped.
- R3: Logical 24..31 of window w are the same storage as logical 8..15 of window (w+1) mod NWIN. Logical 16..23 are private to each window.
- R4: Command encoding: 2'b00 none, 2'b01 save, 2'b10 restore, 2'b11 return-from-trap. A save decrements `ptr` modulo NWIN at the clock edge. Restore and return-from-trap increment it modulo NWIN. With no command, `ptr` holds.
- R5: A save whose target window has its bit set in the mask leaves `ptr` unchanged. `ovf_trap` is then high for the cycle after that edge.
- R6: A restore or return-from-trap whose target window is marked in the mask leaves `ptr` unchanged. `unf_trap` is then high for the cycle after that edge.
- R7: In a cycle that carries a window command, both reads use the old window and the write lands in the new window. If that command traps, the write is discarded.
- R8: After reset, `ptr` is 0, the mask is 1 at bit 1 only, and both trap flags are low.
- R9: When `mask_we` is high, the mask loads `mask_wdata` at the edge. A command in the same cycle is checked against the old mask. An all-zero mask raises no traps.
- R10: A read in the same cycle as a write to the same register returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of pointer, mask and flags |
| rd_a_idx | input | 5 | Logical number, read port A |
| rd_a_data | output | DW | Read data, port A |
| rd_b_idx | input | 5 | Logical number, read port B |
| rd_b_data | output | DW | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Logical number for the write |
| wr_data | input | DW | Write data |
| cmd | input | 2 | Window command (see R4) |
| mask_we | input | 1 | Load the invalid-window mask |
| mask_wdata | input | NWIN | New mask value |
| ptr | output | 5 | Current window pointer |
| mask_q | output | NWIN | Current invalid-window mask |
| ovf_trap | output | 1 | Overflow flag, one cycle after a blocked save |
| unf_trap | output | 1 | Underflow flag, one cycle after a blocked upward move |

## Verification
The renaming is tried with several patterns:
- Writes to an outgoing register followed by a save. These separate true window sharing from a plain copy.
- Writes to a local register in two adjacent windows. These show that locals stay private.
- Writes to globals across a pointer move.

Save chains that run into the mask, and upward moves against the reset mask, show blocked moves apart from wrapped ones. A write issued together with a trapping save shows that the write is suppressed. A write issued together with a successful save shows which window it goes to. Mask loads given in the same cycle as a command show which mask the command is checked against. A full ring of restores under an empty mask confirms the wrap-around.

// File: rtl/winreg_file.sv
module winreg_file #(
  parameter int NWIN = 8,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      rd_a_idx,
  output logic [DW-1:0]   rd_a_data,
  input  logic [4:0]      rd_b_idx,
  output logic [DW-1:0]   rd_b_data,
  input  logic            wr_en,
  input  logic [4:0]      wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic [1:0]      cmd,
  input  logic            mask_we,
  input  logic [NWIN-1:0] mask_wdata,
  output logic [4:0]      ptr,
  output logic [NWIN-1:0] mask_q,
  output logic            ovf_trap,
  output logic            unf_trap
);
  localparam int NPHYS = 8 + 16 * NWIN;
  localparam int PW    = $clog2(NPHYS);
  localparam int WW    = (NWIN > 1) ? $clog2(NWIN) : 1;

  logic [DW-1:0] regs [NPHYS];
  logic [4:0] down_w, up_w, next_w;
  logic       is_save, is_up, block_dn, block_up, blocked;

  function automatic logic [PW-1:0] phys(input logic [4:0] r, input logic [4:0] w);
    int s;
    if (r < 5'd8) return PW'(r);
    s = int'(w) * 16 + int'(r) - 8;
    if (s >= 16 * NWIN) s = s - 16 * NWIN;
    return PW'(s + 8);
  endfunction

  assign is_save  = (cmd == 2'b01);
  assign is_up    = cmd[1];
  assign down_w   = (ptr == 5'd0) ? 5'(NWIN - 1) : ptr - 5'd1;
  assign up_w     = (ptr == 5'(NWIN - 1)) ? 5'd0 : ptr + 5'd1;
  assign block_dn = is_save & mask_q[down_w[WW-1:0]];
  assign block_up = is_up & mask_q[up_w[WW-1:0]];
  assign blocked  = block_dn | block_up;
  assign next_w   = is_save ? down_w : (is_up ? up_w : ptr);

  assign rd_a_data = (rd_a_idx == 5'd0) ? '0 : regs[phys(rd_a_idx, ptr)];
  assign rd_b_data = (rd_b_idx == 5'd0) ? '0 : regs[phys(rd_b_idx, ptr)];

  always_ff @(posedge clk)
    if (wr_en && !blocked && wr_idx != 5'd0)
      regs[phys(wr_idx, next_w)] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ptr      <= 5'd0;
      mask_q   <= NWIN'(2);
      ovf_trap <= 1'b0;
      unf_trap <= 1'b0;
    end else begin
      ovf_trap <= block_dn;
      unf_trap <= block_up;
      if (!blocked) ptr <= next_w;
      if (mask_we) mask_q <= mask_wdata;
    end
endmodule

// File: rtl/winreg_file_chk.sv
module winreg_file_chk #(
  parameter int NWIN = 8,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [4:0]      rd_a_idx,
  input logic [DW-1:0]   rd_a_data,
  input logic [4:0]      rd_b_idx,
  input logic [DW-1:0]   rd_b_data,
  input logic [1:0]      cmd,
  input logic            mask_we,
  input logic [NWIN-1:0] mask_wdata,
  input logic [4:0]      ptr,
  input logic [NWIN-1:0] mask_q,
  input logic            ovf_trap,
  input logic            unf_trap
);
  // R2
  zero_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx == 5'd0 |-> rd_a_data == '0);
  // R2
  zero_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_idx == 5'd0 |-> rd_b_data == '0);
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 2'b00 |=> $stable(ptr));
  // R4
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < 5'(NWIN));
  // R5
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |-> ptr == $past(ptr));
  // R5
  ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_trap) |-> $past(cmd) == 2'b01);
  // R6
  unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_trap |-> ptr == $past(ptr));
  // R6
  one_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_trap && unf_trap));
  // R9
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> mask_q == $past(mask_wdata));
endmodule

bind winreg_file winreg_file_chk #(.NWIN(NWIN), .DW(DW)) chk_i (.*);

// File: tb/winreg_file_tb_top.sv
`timescale 1ns/100ps
module winreg_file_tb_top;
  localparam int NWIN = 8;
  logic clk = 0, rst_n = 0;
  logic [4:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0, ptr;
  logic [31:0] rd_a_data, rd_b_data, wr_data = 0;
  logic wr_en = 0, mask_we = 0, ovf_trap, unf_trap;
  logic [1:0] cmd = 0;
  logic [NWIN-1:0] mask_wdata = 0, mask_q;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  winreg_file #(.NWIN(NWIN), .DW(32)) dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; cmd = 0; wr_en = 0; mask_we = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic step(input logic [1:0] c, input logic we, input logic [4:0] wi, input logic [31:0] wd);
    cmd = c; wr_en = we; wr_idx = wi; wr_data = wd;
    @(posedge clk); #1;
    cmd = 0; wr_en = 0; mask_we = 0;
  endtask

  task automatic rd(input logic [4:0] i, output logic [31:0] v);
    rd_a_idx = i; #0.5; v = rd_a_data;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R8 ptr", 32'(ptr), 0);
    chk("R8 mask", 32'(mask_q), 32'h2);
    chk("R8 ovf", 32'(ovf_trap), 0);
    chk("R8 unf", 32'(unf_trap), 0);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    do_reset();
    step(2'b00, 1, 5'd0, 32'h5);
    rd(5'd0, v); chk("R2 port a", v, 0);
    rd_b_idx = 0; #0.5; chk("R2 port b", rd_b_data, 0);
  endtask

  task automatic t_global();
    logic [31:0] v;
    do_reset();
    step(2'b00, 1, 5'd5, 32'hA5A5);
    step(2'b01, 0, 5'd0, 0);
    chk("R4 save wrap", 32'(ptr), 7);
    rd(5'd5, v); chk("R1 global", v, 32'hA5A5);
    rd_b_idx = 5; #0.5; chk("R1 global port b", rd_b_data, 32'hA5A5);
  endtask

  task automatic t_overlap();
    logic [31:0] v;
    do_reset();
    step(2'b00, 1, 5'd8, 32'h1111);
    step(2'b00, 1, 5'd16, 32'h3333);
    step(2'b01, 0, 5'd0, 0);
    rd(5'd24, v); chk("R3 in aliases caller out", v, 32'h1111);
    step(2'b00, 1, 5'd16, 32'h2222);
    step(2'b10, 0, 5'd0, 0);
    chk("R4 restore", 32'(ptr), 0);
    rd(5'd16, v); chk("R3 local private", v, 32'h3333);
  endtask

  task automatic t_cmd_window();
    logic [31:0] v;
    do_reset();
    step(2'b00, 1, 5'd8, 32'hAAAA);
    rd_a_idx = 8; cmd = 2'b01; wr_en = 1; wr_idx = 8; wr_data = 32'hBBBB;
    #0.5; chk("R7 read old window", rd_a_data, 32'hAAAA);
    @(posedge clk); #1; cmd = 0; wr_en = 0;
    rd(5'd8, v); chk("R7 write new window", v, 32'hBBBB);
    rd(5'd24, v); chk("R7 caller out intact", v, 32'hAAAA);
  endtask

  task automatic t_rdw();
    do_reset();
    step(2'b00, 1, 5'd3, 32'h1);
    rd_a_idx = 3; wr_en = 1; wr_idx = 3; wr_data = 32'h2;
    #0.5; chk("R10 old value", rd_a_data, 32'h1);
    @(posedge clk); #1; wr_en = 0;
    #0.5; chk("R10 new value", rd_a_data, 32'h2);
  endtask

  task automatic t_ovf();
    logic [31:0] v;
    do_reset();
    for (int k = 0; k < 6; k++) step(2'b01, 0, 5'd0, 0);
    chk("R4 six saves", 32'(ptr), 2);
    chk("R5 no early trap", 32'(ovf_trap), 0);
    step(2'b00, 1, 5'd16, 32'hCAFE);
    step(2'b01, 1, 5'd16, 32'hDEAD);
    chk("R5 ovf flag", 32'(ovf_trap), 1);
    chk("R5 ptr held", 32'(ptr), 2);
    rd(5'd16, v); chk("R7 write dropped on trap", v, 32'hCAFE);
    @(posedge clk); #1;
    chk("R5 flag one cycle", 32'(ovf_trap), 0);
  endtask

  task automatic t_unf();
    do_reset();
    step(2'b10, 0, 5'd0, 0);
    chk("R6 restore unf", 32'(unf_trap), 1);
    chk("R6 restore ptr held", 32'(ptr), 0);
    step(2'b11, 0, 5'd0, 0);
    chk("R6 rett unf", 32'(unf_trap), 1);
    chk("R6 rett ptr held", 32'(ptr), 0);
    step(2'b01, 0, 5'd0, 0);
    step(2'b11, 0, 5'd0, 0);
    chk("R4 rett wrap up", 32'(ptr), 0);
    chk("R6 no trap on valid rett", 32'(unf_trap), 0);
  endtask

  task automatic t_mask();
    int traps = 0;
    do_reset();
    mask_we = 1; mask_wdata = '0;
    step(2'b10, 0, 5'd0, 0);
    chk("R9 old mask used", 32'(unf_trap), 1);
    chk("R9 mask loaded", 32'(mask_q), 0);
    for (int k = 0; k < NWIN; k++) begin
      step(2'b10, 0, 5'd0, 0);
      traps += int'(unf_trap);
    end
    chk("R4 full ring wrap", 32'(ptr), 0);
    chk("R9 zero mask no traps", 32'(traps), 0);
    mask_we = 1; mask_wdata = 8'h10;
    step(2'b00, 0, 5'd0, 0);
    for (int k = 0; k < 3; k++) step(2'b10, 0, 5'd0, 0);
    chk("R9 three restores", 32'(ptr), 3);
    step(2'b10, 0, 5'd0, 0);
    chk("R9 new mask traps", 32'(unf_trap), 1);
    chk("R9 ptr held", 32'(ptr), 3);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_zero();
    t_global();
    t_overlap();
    t_cmd_window();
    t_rdw();
    t_ovf();
    t_unf();
    t_mask();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule